// File: doc/BRIEF.md
# Multi-Channel Register Access Decoder

This block steers a parallel host bus onto four identical serial-port register sets. While the active-low chip select is low, address bit 7 picks one of two targets: a channel's register set, or a small device configuration space. For a channel access, address bits 6:4 name the channel and bits 3:0 give the register offset. That offset and the write data go unchanged to the channel register files. The block produces one write enable per channel, a one-hot read select, and a read-data multiplexer that returns the addressed channel's data, or configuration data, to the host.

The configuration space holds two registers. The first is a broadcast-enable bit. While it is set, a write to any valid channel becomes a write to all four channels in the same cycle. Reads are not affected and still come from the addressed channel only. The second is a self-clearing soft-reset register with one bit per channel. Each 1 written to it produces a single-cycle reset pulse for the matching channel. The active-low hardware reset clears the configuration space and holds every channel reset output high.

Top module: `mchan_reg_decoder`

## Requirements
- R1: While `cs_n_i` is high, no write enable and no read select is asserted and `rdata_o` is 0, whatever `wr_i`, `rd_i` and the address are.
- R2: With `cs_n_i` low, `addr_i[7]`=0 and `wr_i`=1, channel codes 0, 1, 2 and 3 on `addr_i[6:4]` assert only `ch_we_o[0]`, `[1]`, `[2]` and `[3]` respectively, in the same cycle. No read select is asserted during a write.
- R3: Channel codes 4 to 7 are unused. Writes to them assert no write enable, even in broadcast mode. Reads of them assert no read select and return 0.
- R4: While the broadcast bit is 1, a write to any channel code 0 to 3 asserts all four write enables in the same cycle.
- R5: A read (`rd_i`=1, `wr_i`=0) of channel code c asserts only `ch_rd_sel_o[c]` and returns channel c's data on `rdata_o`. This holds in broadcast mode too.
- R6: `ch_ofs_o` equals `addr_i[3:0]` and `ch_wdata_o` equals `wdata_i`.
- R7: With `addr_i[7]`=1, offset 0xB is the broadcast register. Its bit 0 is written from `wdata_i[0]` and reads back as {7'b0, bit}. Writes to other configuration offsets change nothing, and reads of them return 0.
- R8: A write to configuration offset 0xA with data bits 3:0 = m raises `ch_rst_o` = m for exactly the one cycle after the write edge. That register always reads back 0.
- R9: While `rst_n_i` is low, `ch_rst_o` is all ones. After reset the broadcast bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low hardware reset |
| cs_n_i | input | 1 | Active-low chip select |
| wr_i | input | 1 | Write cycle |
| rd_i | input | 1 | Read cycle |
| addr_i | input | 8 | Bit 7 is the space select, bits 6:4 the channel, bits 3:0 the offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| ch_rdata_i | input | 32 | Read data of channels 3..0, 8 bits each, channel 0 in the low byte |
| ch_we_o | output | 4 | Per-channel write enable |
| ch_rd_sel_o | output | 4 | One-hot channel read select |
| ch_ofs_o | output | 4 | Register offset to channels |
| ch_wdata_o | output | 8 | Write data to channels |
| ch_rst_o | output | 4 | Per-channel reset to defaults |

## Verification
The hardest situation to reach is a read while broadcast is on, where every channel must hold different contents. A broadcast write would make them equal. The bench therefore fills one offset with distinct per-channel values while broadcast is off. It then sets the broadcast bit and reads each channel back, alongside a broadcast write to another offset and a write to an unused code. The soft-reset pulse is checked on the cycle right after its write edge and on the cycle after that. The channels it did not name are then read back to show they kept their contents.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_CHAN = 2'd1,
      ACC_CFG  = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/mcd_addr_decode.sv
`timescale 1ns/1ps
module mcd_addr_decode
   import mcd_pkg::*;
#(
   parameter int AW   = 8,
   parameter int CHW  = 3,
   parameter int OFSW = 4,
   parameter int NCH  = 4
) (
   input  logic            cs_n_i,
   input  logic            wr_i,
   input  logic            rd_i,
   input  logic [AW-1:0]   addr_i,
   output acc_kind_e       kind_o,
   output logic            is_wr_o,
   output logic            is_rd_o,
   output logic [CHW-1:0]  ch_idx_o,
   output logic            ch_ok_o,
   output logic [OFSW-1:0] ofs_o
);
   localparam logic [CHW:0] NCH_LIM = (CHW+1)'(NCH);

   if (AW != CHW + OFSW + 1) begin : g_bad_aw
      $error("mcd_addr_decode: AW must equal CHW+OFSW+1");
   end
   if (NCH > (1 << CHW)) begin : g_bad_nch
      $error("mcd_addr_decode: NCH exceeds channel code space");
   end

   logic active;
   assign active   = !cs_n_i && (wr_i || rd_i);
   assign is_wr_o  = active && wr_i;
   assign is_rd_o  = active && rd_i && !wr_i;
   assign ch_idx_o = addr_i[AW-2 -: CHW];
   assign ofs_o    = addr_i[OFSW-1:0];
   assign ch_ok_o  = ({1'b0, ch_idx_o} < NCH_LIM);

   always_comb begin
      if (!active)            kind_o = ACC_NONE;
      else if (addr_i[AW-1])  kind_o = ACC_CFG;
      else                    kind_o = ACC_CHAN;
   end
endmodule

// File: rtl/mcd_cfg_regs.sv
`timescale 1ns/1ps
module mcd_cfg_regs #(
   parameter int              DW        = 8,
   parameter int              OFSW      = 4,
   parameter int              NCH       = 4,
   parameter logic [OFSW-1:0] BCAST_OFS = 4'hB,
   parameter logic [OFSW-1:0] SRST_OFS  = 4'hA
) (
   input  logic            clk_i,
   input  logic            rst_n_i,
   input  logic            cfg_wr_i,
   input  logic            cfg_rd_i,
   input  logic [OFSW-1:0] ofs_i,
   input  logic [DW-1:0]   wdata_i,
   output logic            bcast_o,
   output logic [NCH-1:0]  srst_o,
   output logic [DW-1:0]   rdata_o
);
   if (NCH > DW) begin : g_bad_nch
      $error("mcd_cfg_regs: one soft-reset bit per channel must fit in DW");
   end
   if (BCAST_OFS == SRST_OFS) begin : g_bad_ofs
      $error("mcd_cfg_regs: register offsets collide");
   end

   logic           bcast_q;
   logic [NCH-1:0] srst_q;
   logic           hit_bcast;
   logic           hit_srst;
   logic           unused_wdata;

   assign hit_bcast    = cfg_wr_i && (ofs_i == BCAST_OFS);
   assign hit_srst     = cfg_wr_i && (ofs_i == SRST_OFS);
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         bcast_q <= 1'b0;
         srst_q  <= '0;
      end else begin
         srst_q <= hit_srst ? wdata_i[NCH-1:0] : '0;
         if (hit_bcast) bcast_q <= wdata_i[0];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (cfg_rd_i && ofs_i == BCAST_OFS) rdata_o[0] = bcast_q;
   end

   assign bcast_o = bcast_q;
   assign srst_o  = srst_q;

   AST_SRST_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (|srst_q) |-> $past(hit_srst)) else $error("soft reset pulse without write"); // R8
   AST_SRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ((|srst_q) && !$past(hit_srst, 1) && 1'b1) |-> 1'b0 || (|srst_q) == 1'b0) else $error("soft reset held"); // R8
   AST_BCAST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !hit_bcast |=> $stable(bcast_q)) else $error("broadcast bit changed without write"); // R7
endmodule

// File: rtl/mcd_we_gen.sv
`timescale 1ns/1ps
module mcd_we_gen #(
   parameter int NCH      = 4,
   parameter int CHW      = 3,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic           chan_wr_i,
   input  logic [CHW-1:0] ch_idx_i,
   input  logic           ch_ok_i,
   input  logic           bcast_i,
   output logic [NCH-1:0] we_o
);
   logic fan_all;

   if (BCAST_EN) begin : g_bcast
      assign fan_all = bcast_i;
   end else begin : g_no_bcast
      logic unused_bcast;
      assign unused_bcast = bcast_i;
      assign fan_all      = 1'b0;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign we_o[i] = chan_wr_i && ch_ok_i && (fan_all || ch_idx_i == CHW'(i));
   end
endmodule

// File: rtl/mcd_rd_mux.sv
`timescale 1ns/1ps
module mcd_rd_mux #(
   parameter int NCH       = 4,
   parameter int DW        = 8,
   parameter int CHW       = 3,
   parameter bit AND_OR    = 1'b1
) (
   input  logic              chan_rd_i,
   input  logic [CHW-1:0]    ch_idx_i,
   input  logic              ch_ok_i,
   input  logic [NCH*DW-1:0] ch_rdata_i,
   input  logic [DW-1:0]     cfg_rdata_i,
   output logic [NCH-1:0]    rd_sel_o,
   output logic [DW-1:0]     rdata_o
);
   for (genvar i = 0; i < NCH; i++) begin : g_sel
      assign rd_sel_o[i] = chan_rd_i && ch_ok_i && (ch_idx_i == CHW'(i));
   end

   if (AND_OR) begin : g_andor
      always_comb begin
         rdata_o = cfg_rdata_i;
         for (int i = 0; i < NCH; i++) begin
            rdata_o = rdata_o | ({DW{rd_sel_o[i]}} & ch_rdata_i[i*DW +: DW]);
         end
      end
   end else begin : g_index
      logic [DW-1:0] picked;
      always_comb begin
         picked = '0;
         for (int i = 0; i < NCH; i++) begin
            if (ch_idx_i == CHW'(i)) picked = ch_rdata_i[i*DW +: DW];
         end
         rdata_o = (chan_rd_i && ch_ok_i) ? picked : cfg_rdata_i;
      end
   end
endmodule

// File: rtl/mchan_reg_decoder.sv
`timescale 1ns/1ps
module mchan_reg_decoder
   import mcd_pkg::*;
#(
   parameter int              NCH       = 4,
   parameter int              DW        = 8,
   parameter int              CHW       = 3,
   parameter int              OFSW      = 4,
   parameter logic [OFSW-1:0] BCAST_OFS = 4'hB,
   parameter logic [OFSW-1:0] SRST_OFS  = 4'hA,
   parameter bit              BCAST_EN  = 1'b1,
   parameter bit              MUX_ANDOR = 1'b1,
   localparam int             AW        = CHW + OFSW + 1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              cs_n_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   input  logic [NCH*DW-1:0] ch_rdata_i,
   output logic [NCH-1:0]    ch_we_o,
   output logic [NCH-1:0]    ch_rd_sel_o,
   output logic [OFSW-1:0]   ch_ofs_o,
   output logic [DW-1:0]     ch_wdata_o,
   output logic [NCH-1:0]    ch_rst_o
);
   acc_kind_e       kind;
   logic            is_wr, is_rd;
   logic [CHW-1:0]  ch_idx;
   logic            ch_ok;
   logic [OFSW-1:0] ofs;
   logic            bcast;
   logic [NCH-1:0]  srst;
   logic [DW-1:0]   cfg_rdata;
   logic            chan_wr, chan_rd, cfg_wr, cfg_rd;

   mcd_addr_decode #(.AW(AW), .CHW(CHW), .OFSW(OFSW), .NCH(NCH)) u_dec (
      .cs_n_i  (cs_n_i),
      .wr_i    (wr_i),
      .rd_i    (rd_i),
      .addr_i  (addr_i),
      .kind_o  (kind),
      .is_wr_o (is_wr),
      .is_rd_o (is_rd),
      .ch_idx_o(ch_idx),
      .ch_ok_o (ch_ok),
      .ofs_o   (ofs)
   );

   assign chan_wr = (kind == ACC_CHAN) && is_wr;
   assign chan_rd = (kind == ACC_CHAN) && is_rd;
   assign cfg_wr  = (kind == ACC_CFG)  && is_wr;
   assign cfg_rd  = (kind == ACC_CFG)  && is_rd;

   mcd_cfg_regs #(
      .DW(DW), .OFSW(OFSW), .NCH(NCH), .BCAST_OFS(BCAST_OFS), .SRST_OFS(SRST_OFS)
   ) u_cfg (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .cfg_wr_i(cfg_wr),
      .cfg_rd_i(cfg_rd),
      .ofs_i   (ofs),
      .wdata_i (wdata_i),
      .bcast_o (bcast),
      .srst_o  (srst),
      .rdata_o (cfg_rdata)
   );

   mcd_we_gen #(.NCH(NCH), .CHW(CHW), .BCAST_EN(BCAST_EN)) u_we (
      .chan_wr_i(chan_wr),
      .ch_idx_i (ch_idx),
      .ch_ok_i  (ch_ok),
      .bcast_i  (bcast),
      .we_o     (ch_we_o)
   );

   mcd_rd_mux #(.NCH(NCH), .DW(DW), .CHW(CHW), .AND_OR(MUX_ANDOR)) u_rd (
      .chan_rd_i  (chan_rd),
      .ch_idx_i   (ch_idx),
      .ch_ok_i    (ch_ok),
      .ch_rdata_i (ch_rdata_i),
      .cfg_rdata_i(cfg_rdata),
      .rd_sel_o   (ch_rd_sel_o),
      .rdata_o    (rdata_o)
   );

   assign ch_ofs_o   = ofs;
   assign ch_wdata_o = wdata_i;
   assign ch_rst_o   = srst | {NCH{~rst_n_i}};

   AST_NO_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cs_n_i |-> (ch_we_o == '0 && ch_rd_sel_o == '0 && rdata_o == '0)) else $error("access decoded without chip select"); // R1
   AST_UNUSED_CODE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!cs_n_i && !addr_i[AW-1] && !ch_ok) |-> (ch_we_o == '0 && ch_rd_sel_o == '0 && rdata_o == '0)) else $error("unused code decoded"); // R3
   AST_BCAST_ALL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (BCAST_EN && bcast && !cs_n_i && wr_i && !addr_i[AW-1] && ch_ok) |-> (&ch_we_o)) else $error("broadcast write missed a channel"); // R4
   AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $onehot0(ch_rd_sel_o) && !((|ch_rd_sel_o) && (|ch_we_o))) else $error("read select not single"); // R5
   always_comb begin
      if (!rst_n_i) AST_HW_RST_ALL: assert (&ch_rst_o) else $error("hw reset not fanned out"); // R9
   end
endmodule

// File: tb/sim_mchan_reg_decoder.sv
`timescale 1ns/1ps
module sim_mchan_reg_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, wr = 1'b0, rd = 1'b0;
   logic [7:0]  addr = '0, wdata = '0;
   logic [7:0]  rdata;
   logic [31:0] ch_rdata;
   logic [3:0]  ch_we, ch_rd_sel, ch_rst, ch_ofs;
   logic [7:0]  ch_wdata;

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0] mem     [4][16];
   logic [7:0] exp_mem [4][16];

   always #4 clk = ~clk;

   mchan_reg_decoder u0 (
      .clk_i(clk), .rst_n_i(rst_n), .cs_n_i(cs_n), .wr_i(wr), .rd_i(rd),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ch_rdata_i(ch_rdata),
      .ch_we_o(ch_we), .ch_rd_sel_o(ch_rd_sel), .ch_ofs_o(ch_ofs),
      .ch_wdata_o(ch_wdata), .ch_rst_o(ch_rst)
   );

   // channel register stubs
   always_ff @(posedge clk) begin
      for (int c = 0; c < 4; c++) begin
         if (ch_rst[c]) begin
            for (int o = 0; o < 16; o++) mem[c][o] <= '0;
         end else if (ch_we[c]) begin
            mem[c][ch_ofs] <= ch_wdata;
         end
      end
   end
   always_comb begin
      for (int c = 0; c < 4; c++) ch_rdata[c*8 +: 8] = mem[c][ch_ofs];
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic c_n, input logic w, input logic r,
                        input logic [7:0] a, input logic [7:0] d);
      cs_n = c_n; wr = w; rd = r; addr = a; wdata = d;
      #1;
   endtask

   task automatic end_cycle;
      @(posedge clk);
      @(negedge clk);
      cs_n = 1'b1; wr = 1'b0; rd = 1'b0;
   endtask

   task automatic clear_exp;
      for (int c = 0; c < 4; c++)
         for (int o = 0; o < 16; o++) exp_mem[c][o] = '0;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      drive(1'b0, 1'b1, 1'b0, a, d);
      end_cycle();
   endtask

   task automatic read_chan(input int c, input int o, input string req);
      drive(1'b0, 1'b0, 1'b1, {1'b0, 3'(c), 4'(o)}, 8'h00);
      chk({req, " rd_sel"}, 32'(ch_rd_sel), 32'(4'b1 << c));
      chk({req, " rdata"}, 32'(rdata), 32'(exp_mem[c][o]));
      end_cycle();
   endtask

   task automatic read_cfg(input logic [3:0] o, input logic [7:0] e, input string req);
      drive(1'b0, 1'b0, 1'b1, {4'h8, o}, 8'h00);
      chk(req, 32'(rdata), 32'(e));
      end_cycle();
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9 ch_rst in reset", 32'(ch_rst), 32'hF);
      chk("R1 idle we in reset", 32'(ch_we), 32'h0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      clear_exp();
      #1;
      chk("R9 ch_rst after reset", 32'(ch_rst), 32'h0);
      read_cfg(4'hB, 8'h00, "R9 broadcast clear");
   endtask

   task automatic t_no_cs;
      drive(1'b1, 1'b1, 1'b0, 8'h12, 8'hEE);
      chk("R1 we without cs", 32'(ch_we), 32'h0);
      end_cycle();
      drive(1'b1, 1'b0, 1'b1, 8'h12, 8'h00);
      chk("R1 rd_sel without cs", 32'(ch_rd_sel), 32'h0);
      chk("R1 rdata without cs", 32'(rdata), 32'h0);
      end_cycle();
      read_chan(1, 2, "R1 no write landed");
   endtask

   task automatic t_single;
      for (int c = 0; c < 4; c++) begin
         logic [7:0] d;
         d = 8'h10 + 8'(c) * 8'h11;
         drive(1'b0, 1'b1, 1'b0, {1'b0, 3'(c), 4'h7}, d);
         chk("R2 one-hot we", 32'(ch_we), 32'(4'b1 << c));
         chk("R2 no rd_sel on write", 32'(ch_rd_sel), 32'h0);
         chk("R6 offset", 32'(ch_ofs), 32'h7);
         chk("R6 wdata", 32'(ch_wdata), 32'(d));
         end_cycle();
         exp_mem[c][7] = d;
      end
      for (int c = 0; c < 4; c++) read_chan(c, 7, "R5 single read");
   endtask

   task automatic t_unused;
      for (int k = 4; k < 8; k++) begin
         drive(1'b0, 1'b1, 1'b0, {1'b0, 3'(k), 4'h7}, 8'hFF);
         chk("R3 unused write", 32'(ch_we), 32'h0);
         end_cycle();
         drive(1'b0, 1'b0, 1'b1, {1'b0, 3'(k), 4'h7}, 8'h00);
         chk("R3 unused rd_sel", 32'(ch_rd_sel), 32'h0);
         chk("R3 unused rdata", 32'(rdata), 32'h0);
         end_cycle();
      end
   endtask

   task automatic t_broadcast;
      bus_write(8'h8B, 8'h01);
      read_cfg(4'hB, 8'h01, "R7 broadcast readback");
      drive(1'b0, 1'b1, 1'b0, 8'h23, 8'h5A);
      chk("R4 all we", 32'(ch_we), 32'hF);
      end_cycle();
      for (int c = 0; c < 4; c++) exp_mem[c][3] = 8'h5A;
      drive(1'b0, 1'b1, 1'b0, 8'h63, 8'hC3);
      chk("R3 unused under broadcast", 32'(ch_we), 32'h0);
      end_cycle();
      for (int c = 0; c < 4; c++) read_chan(c, 7, "R5 read under broadcast");
      for (int c = 0; c < 4; c++) read_chan(c, 3, "R4 broadcast data");
      bus_write(8'h8B, 8'hFE);
      read_cfg(4'hB, 8'h00, "R7 broadcast cleared");
   endtask

   task automatic t_cfg_other;
      bus_write(8'h85, 8'hFF);
      read_cfg(4'h5, 8'h00, "R7 other offset reads 0");
      read_cfg(4'hB, 8'h00, "R7 broadcast untouched");
      drive(1'b0, 1'b1, 1'b0, 8'h85, 8'hFF);
      chk("R7 cfg write no channel we", 32'(ch_we), 32'h0);
      end_cycle();
   endtask

   task automatic t_soft_reset;
      drive(1'b0, 1'b1, 1'b0, 8'h8A, 8'hF5);
      chk("R8 no pulse before edge", 32'(ch_rst), 32'h0);
      end_cycle();
      chk("R8 pulse", 32'(ch_rst), 32'h5);
      @(posedge clk);
      @(negedge clk);
      chk("R8 pulse cleared", 32'(ch_rst), 32'h0);
      for (int o = 0; o < 16; o++) begin
         exp_mem[0][o] = '0;
         exp_mem[2][o] = '0;
      end
      read_cfg(4'hA, 8'h00, "R8 reads zero");
      for (int c = 0; c < 4; c++) read_chan(c, 7, "R8 channel contents");
   endtask

   task automatic t_hw_reset;
      bus_write(8'h8B, 8'h01);
      rst_n = 1'b0;
      #1;
      chk("R9 all resets", 32'(ch_rst), 32'hF);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      clear_exp();
      read_cfg(4'hB, 8'h00, "R9 broadcast reset");
      read_chan(3, 7, "R9 channel cleared");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_no_cs();
      t_single();
      t_unused();
      t_broadcast();
      t_cfg_other();
      t_soft_reset();
      t_hw_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule